// File: doc/BRIEF.md
# Frame-synchronous register list loader

This block applies a list of register updates, held in memory, to a bank of configuration registers once per video frame. Host software writes a list base pointer and an entry count through a small control port. At each frame-end event the block takes the pointer and fetches the list, one 64-bit entry at a time, over a memory read port. Each entry pairs a target register address with a data word, and the block drives that pair onto a register write port.

Once the list has been applied, the block waits for the frame-start event and raises a frame-start flag. A frame-end flag is raised at every frame boundary. A list stays in force until the host supplies a new one. Until then the same list is fetched and applied again at every frame end, so software can leave a fixed configuration in place without writing anything more. Only one pointer can wait to be taken. A status bit shows whether the host has written a pointer that the hardware has not yet taken.

Both the memory request and the register write use valid/ready handshakes. While valid is high and ready is low, the block holds valid high and keeps its payload unchanged. The block has at most one memory request outstanding. It does not issue the next request until the previous entry has been accepted on the register write port. The response channel is accepted only while the block waits for a response.

Top module: `frame_reglist_loader`

## Requirements
- R1: A host write to control address 0 stores the list base pointer and sets the pending bit, which is status bit 0 at control address 2.
- R2: At a frame-end event the block copies the stored pointer and count into its working copy and clears the pending bit. A host write to address 0 in that same cycle leaves the bit set.
- R3: When no pointer has been written since the last copy, each frame-end event fetches and applies the working list again, with identical writes.
- R4: A pointer written while a list is being applied does not change that pass. The new list is applied at the next frame-end event.
- R5: Entry k is read from address base + 8*k, for k = 0 up to count-1. Response bits [63:32] give the register address and bits [31:0] the data. Entries are written in order of increasing k.
- R6: The frame-start flag (status bit 1) is set by a frame-start event only after the list has been applied. A frame-start event that arrives while the block is idle is ignored.
- R7: Every frame-end event sets the frame-end flag (status bit 2).
- R8: An entry count of zero (written at control address 1) makes a frame-end event skip the fetch. The block then waits directly for frame start.
- R9: Before any pointer has ever been written, a frame-end event applies no list, and both flags are still raised.
- R10: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 leaves it unchanged. After reset the status reads zero and both interrupt outputs are low.
- R11: mem_req_valid and cfg_wr_valid, together with their payloads, are held stable until accepted. The two are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_wr_en | input | 1 | Control write strobe |
| hst_wr_addr | input | 2 | Control write address (0 pointer, 1 count, 2 status clear) |
| hst_wr_data | input | 32 | Control write data |
| hst_rd_addr | input | 2 | Control read address |
| hst_rd_data | output | 32 | Control read data (combinational) |
| frame_end_evt | input | 1 | Frame-end event pulse |
| frame_start_evt | input | 1 | Frame-start event pulse |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request ready |
| mem_req_addr | output | 32 | Byte address of the list entry |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Memory response ready |
| mem_rsp_data | input | 64 | List entry: register address in [63:32], data in [31:0] |
| cfg_wr_valid | output | 1 | Register write valid |
| cfg_wr_ready | input | 1 | Register write ready |
| cfg_wr_addr | output | 32 | Register write address |
| cfg_wr_data | output | 32 | Register write data |
| irq_frame_start | output | 1 | Sticky frame-start flag |
| irq_frame_end | output | 1 | Sticky frame-end flag |

## Verification
The hardest case to reach is a host pointer write that arrives while a list is still being fetched. The new pointer must stay pending, must not disturb the pass in progress, and must be taken at the next boundary. The bench slows both the memory request and the register write with fixed ready patterns, so each pass lasts many cycles. It writes a new pointer a few cycles after the frame-end pulse. Then it checks that the writes it captures still come from the old list, that the pending bit is still set, and that the following frame applies the new list.

// File: rtl/reglist_pkg.sv
package reglist_pkg;
  localparam logic [1:0] HA_PTR  = 2'd0;
  localparam logic [1:0] HA_CNT  = 2'd1;
  localparam logic [1:0] HA_STAT = 2'd2;

  localparam int ST_PEND  = 0;
  localparam int ST_START = 1;
  localparam int ST_END   = 2;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_RSP,
    SQ_WR,
    SQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/reglist_host_regs.sv
module reglist_host_regs
  import reglist_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             latch_i,
  input  logic             start_pulse_i,
  input  logic             frame_end_i,
  output logic [AW-1:0]    stg_ptr_o,
  output logic [CNT_W-1:0] stg_cnt_o,
  output logic             pend_o,
  output logic             irq_start_o,
  output logic             irq_end_o
);
  logic ptr_wr, cnt_wr, stat_wr;

  assign ptr_wr  = wr_en && (wr_addr == HA_PTR);
  assign cnt_wr  = wr_en && (wr_addr == HA_CNT);
  assign stat_wr = wr_en && (wr_addr == HA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_ptr_o   <= '0;
      stg_cnt_o   <= '0;
      pend_o      <= 1'b0;
      irq_start_o <= 1'b0;
      irq_end_o   <= 1'b0;
    end else begin
      if (ptr_wr) stg_ptr_o <= wr_data[AW-1:0];
      if (cnt_wr) stg_cnt_o <= wr_data[CNT_W-1:0];
      if (ptr_wr)       pend_o <= 1'b1;
      else if (latch_i) pend_o <= 1'b0;
      if (start_pulse_i) irq_start_o <= 1'b1;
      else if (stat_wr && wr_data[ST_START]) irq_start_o <= 1'b0;
      if (frame_end_i) irq_end_o <= 1'b1;
      else if (stat_wr && wr_data[ST_END]) irq_end_o <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      HA_PTR:  rd_data[AW-1:0] = stg_ptr_o;
      HA_CNT:  rd_data[CNT_W-1:0] = stg_cnt_o;
      HA_STAT: begin
        rd_data[ST_PEND]  = pend_o;
        rd_data[ST_START] = irq_start_o;
        rd_data[ST_END]   = irq_end_o;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/reglist_fetch_seq.sv
module reglist_fetch_seq
  import reglist_pkg::*;
#(
  parameter int AW    = 32,
  parameter int RW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end_i,
  input  logic             frame_start_i,
  input  logic             pend_i,
  input  logic [AW-1:0]    stg_ptr_i,
  input  logic [CNT_W-1:0] stg_cnt_i,
  output logic             latch_o,
  output logic             start_pulse_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [AW-1:0]    req_addr_o,
  input  logic             rsp_valid_i,
  output logic             rsp_ready_o,
  input  logic [RW+DW-1:0] rsp_data_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [RW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o
);
  localparam int ENTRY_SHIFT = $clog2((RW + DW) / 8);

  seq_state_e       state_q;
  logic [AW-1:0]    work_ptr_q;
  logic [CNT_W-1:0] work_cnt_q;
  logic             have_list_q;
  logic [CNT_W-1:0] idx_q;
  logic [RW-1:0]    ent_addr_q;
  logic [DW-1:0]    ent_data_q;
  logic [CNT_W:0]   idx_inc;
  logic [CNT_W-1:0] cnt_next;
  logic             have_next;

  assign idx_inc   = {1'b0, idx_q} + 1'b1;
  assign latch_o   = (state_q == SQ_IDLE) && frame_end_i && pend_i;
  assign have_next = have_list_q || pend_i;
  assign cnt_next  = pend_i ? stg_cnt_i : work_cnt_q;

  assign start_pulse_o = (state_q == SQ_WAIT) && frame_start_i;
  assign req_valid_o   = (state_q == SQ_REQ);
  assign req_addr_o    = work_ptr_q + (AW'(idx_q) << ENTRY_SHIFT);
  assign rsp_ready_o   = (state_q == SQ_RSP);
  assign wr_valid_o    = (state_q == SQ_WR);
  assign wr_addr_o     = ent_addr_q;
  assign wr_data_o     = ent_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      work_ptr_q  <= '0;
      work_cnt_q  <= '0;
      have_list_q <= 1'b0;
      idx_q       <= '0;
      ent_addr_q  <= '0;
      ent_data_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (frame_end_i) begin
          if (pend_i) begin
            work_ptr_q  <= stg_ptr_i;
            work_cnt_q  <= stg_cnt_i;
            have_list_q <= 1'b1;
          end
          idx_q <= '0;
          if (have_next && (cnt_next != '0)) state_q <= SQ_REQ;
          else                               state_q <= SQ_WAIT;
        end
        SQ_REQ: if (req_ready_i) state_q <= SQ_RSP;
        SQ_RSP: if (rsp_valid_i) begin
          ent_addr_q <= rsp_data_i[RW+DW-1:DW];
          ent_data_q <= rsp_data_i[DW-1:0];
          state_q    <= SQ_WR;
        end
        SQ_WR: if (wr_ready_i) begin
          idx_q <= idx_inc[CNT_W-1:0];
          if (idx_inc == {1'b0, work_cnt_q}) state_q <= SQ_WAIT;
          else                               state_q <= SQ_REQ;
        end
        SQ_WAIT: if (frame_start_i) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_reglist_loader.sv
module frame_reglist_loader
  import reglist_pkg::*;
#(
  parameter int AW    = 32,
  parameter int RW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_wr_en,
  input  logic [1:0]       hst_wr_addr,
  input  logic [31:0]      hst_wr_data,
  input  logic [1:0]       hst_rd_addr,
  output logic [31:0]      hst_rd_data,
  input  logic             frame_end_evt,
  input  logic             frame_start_evt,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [RW+DW-1:0] mem_rsp_data,
  output logic             cfg_wr_valid,
  input  logic             cfg_wr_ready,
  output logic [RW-1:0]    cfg_wr_addr,
  output logic [DW-1:0]    cfg_wr_data,
  output logic             irq_frame_start,
  output logic             irq_frame_end
);
  logic             latch;
  logic             start_pulse;
  logic             pend;
  logic [AW-1:0]    stg_ptr;
  logic [CNT_W-1:0] stg_cnt;

  reglist_host_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(hst_wr_en), .wr_addr(hst_wr_addr), .wr_data(hst_wr_data),
    .rd_addr(hst_rd_addr), .rd_data(hst_rd_data),
    .latch_i(latch), .start_pulse_i(start_pulse), .frame_end_i(frame_end_evt),
    .stg_ptr_o(stg_ptr), .stg_cnt_o(stg_cnt), .pend_o(pend),
    .irq_start_o(irq_frame_start), .irq_end_o(irq_frame_end)
  );

  reglist_fetch_seq #(.AW(AW), .RW(RW), .DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .frame_end_i(frame_end_evt), .frame_start_i(frame_start_evt),
    .pend_i(pend), .stg_ptr_i(stg_ptr), .stg_cnt_i(stg_cnt),
    .latch_o(latch), .start_pulse_o(start_pulse),
    .req_valid_o(mem_req_valid), .req_ready_i(mem_req_ready), .req_addr_o(mem_req_addr),
    .rsp_valid_i(mem_rsp_valid), .rsp_ready_o(mem_rsp_ready), .rsp_data_i(mem_rsp_data),
    .wr_valid_o(cfg_wr_valid), .wr_ready_i(cfg_wr_ready),
    .wr_addr_o(cfg_wr_addr), .wr_data_o(cfg_wr_data)
  );
endmodule

// File: rtl/frame_reglist_loader_chk.sv
module frame_reglist_loader_chk #(
  parameter int AW = 32,
  parameter int RW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hst_wr_en,
  input logic [1:0]    hst_wr_addr,
  input logic          frame_end_evt,
  input logic          frame_start_evt,
  input logic          pend,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          cfg_wr_valid,
  input logic          cfg_wr_ready,
  input logic [RW-1:0] cfg_wr_addr,
  input logic [DW-1:0] cfg_wr_data,
  input logic          irq_frame_start,
  input logic          irq_frame_end
);
  // R1
  ptr_write_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr_en && hst_wr_addr == 2'd0) |=> pend);

  // R7
  frame_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_evt |=> irq_frame_end);

  // R6
  start_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_frame_start) |-> $past(frame_start_evt));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && !cfg_wr_ready) |=>
      (cfg_wr_valid && $stable(cfg_wr_addr) && $stable(cfg_wr_data)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && cfg_wr_valid));
endmodule

bind frame_reglist_loader frame_reglist_loader_chk #(.AW(AW), .RW(RW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hst_wr_en(hst_wr_en), .hst_wr_addr(hst_wr_addr),
  .frame_end_evt(frame_end_evt), .frame_start_evt(frame_start_evt),
  .pend(pend),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready),
  .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
  .irq_frame_start(irq_frame_start), .irq_frame_end(irq_frame_end)
);

// File: tb/frame_reglist_loader_test.sv
`timescale 1ns/1ps
module frame_reglist_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr_en = 1'b0;
  logic [1:0]  hst_wr_addr = '0;
  logic [31:0] hst_wr_data = '0;
  logic [1:0]  hst_rd_addr = '0;
  logic [31:0] hst_rd_data;
  logic        frame_end_evt = 1'b0;
  logic        frame_start_evt = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        cfg_wr_valid;
  logic        cfg_wr_ready = 1'b0;
  logic [31:0] cfg_wr_addr;
  logic [31:0] cfg_wr_data;
  logic        irq_frame_start;
  logic        irq_frame_end;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int nw = 0;
  logic [31:0] wa [0:15];
  logic [31:0] wd [0:15];

  always #10 clk = ~clk;

  frame_reglist_loader uut (.*);

  function automatic logic [31:0] ent_reg(input logic [31:0] a);
    return {16'hA000, a[15:0]};
  endfunction
  function automatic logic [31:0] ent_dat(input logic [31:0] a);
    return a * 32'd3 + 32'd1;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    cfg_wr_ready  <= (cyc % 3) != 0;
    mem_req_ready <= (cyc % 2) == 0;
  end

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= {ent_reg(mem_req_addr), ent_dat(mem_req_addr)};
    end else if (mem_rsp_valid && mem_rsp_ready) begin
      mem_rsp_valid <= 1'b0;
    end
    if (cfg_wr_valid && cfg_wr_ready && nw < 16) begin
      wa[nw] <= cfg_wr_addr;
      wd[nw] <= cfg_wr_data;
      nw <= nw + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr_en = 1'b1; hst_wr_addr = a; hst_wr_data = d;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic status(output logic [31:0] s);
    @(negedge clk);
    hst_rd_addr = 2'd2;
    #1 s = hst_rd_data;
  endtask

  task automatic pulse_end();
    @(negedge clk); frame_end_evt = 1'b1;
    @(negedge clk); frame_end_evt = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start_evt = 1'b1;
    @(negedge clk); frame_start_evt = 1'b0;
  endtask

  task automatic check_list(input string req, input logic [31:0] base, input int cnt);
    check({req, " count"}, nw, cnt);
    for (int k = 0; k < cnt && k < 16; k++) begin
      check({req, " addr"}, wa[k], ent_reg(base + 32'(8 * k)));
      check({req, " data"}, wd[k], ent_dat(base + 32'(8 * k)));
    end
  endtask

  task automatic run_frame();
    nw = 0;
    pulse_end();
    repeat (120) @(negedge clk);
    pulse_start();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    status(s);
    check("R10 reset status", s, 32'h0);
    check("R10 reset irqs", {30'h0, irq_frame_start, irq_frame_end}, 32'h0);

    // R9 no list ever written
    run_frame();
    check("R9 no writes", nw, 0);
    status(s);
    check("R9 both flags", s, 32'h6);

    // R10 w1c: clear only start, then end
    hwrite(2'd2, 32'h2);
    status(s);
    check("R10 clear start", s, 32'h4);
    hwrite(2'd2, 32'h0);
    status(s);
    check("R10 write zero", s, 32'h4);
    hwrite(2'd2, 32'h4);
    status(s);
    check("R10 clear end", s, 32'h0);

    // R6 frame start while idle ignored
    pulse_start();
    status(s);
    check("R6 idle start ignored", s, 32'h0);

    // R5 sweep counts and bases
    for (int c = 1; c <= 5; c++) begin
      base = 32'h1000 + 32'(c * 32'h140);
      hwrite(2'd1, 32'(c));
      hwrite(2'd0, base);
      status(s);
      check("R1 pending set", s & 32'h1, 32'h1);
      run_frame();
      check_list("R5 list", base, c);
      status(s);
      check("R2 pending cleared", s & 32'h1, 32'h0);
      check("R6 R7 flags", s & 32'h6, 32'h6);
      hwrite(2'd2, 32'h6);
    end

    // R3 reuse of last list (base for c=5, count 5)
    base = 32'h1000 + 32'(5 * 32'h140);
    run_frame();
    check_list("R3 reuse", base, 5);
    run_frame();
    check_list("R3 reuse again", base, 5);

    // R4 pointer written mid-fetch
    hwrite(2'd1, 32'd3);
    hwrite(2'd0, 32'h4000);
    nw = 0;
    pulse_end();
    repeat (4) @(negedge clk);
    hwrite(2'd0, 32'h5000);
    repeat (120) @(negedge clk);
    pulse_start();
    @(negedge clk);
    check_list("R4 current pass", 32'h4000, 3);
    status(s);
    check("R4 new still pending", s & 32'h1, 32'h1);
    run_frame();
    check_list("R4 next pass", 32'h5000, 3);

    // R8 zero count skips fetch, start still fires
    hwrite(2'd2, 32'h6);
    hwrite(2'd1, 32'd0);
    hwrite(2'd0, 32'h6000);
    nw = 0;
    pulse_end();
    pulse_start();
    repeat (20) @(negedge clk);
    check("R8 no writes", nw, 0);
    status(s);
    check("R8 flags", s, 32'h6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule